// File: doc/BRIEF.md
# Dual-CPU Interrupt Routing Mapper

This block gathers a vector of level-sensitive interrupt sources and steers each one, separately for each of two processors, onto one of several interrupt-request output lines. Every processor owns a bank of registers:
- a mask, where a 1 bit blocks a source;
- a read-only status view of the sources that are active and not blocked;
- one route register per source, which chooses the output line;
- a mailbox with set and clear ports, used for messages between processors;
- a latched pending register for bridge interrupts, with a write-one-to-clear port.

Software reaches all of this through a simple word-addressed read/write bus. Each request lasts one cycle and is always accepted, so there is no back-pressure. Read data comes back with a valid strobe on the next cycle.

A processor's effective source vector is the OR of three things: the external levels, that processor's bridge pending bits, and one mailbox bit. The mailbox bit sits at source index `MBOX_SRC` (default 26) and is high while any of the upper 16 mailbox bits is set. Each output line is the OR of all unblocked sources whose route register names that line. The status register and the lines are both registered, so software sees the same picture on both. Software services the highest-numbered status bit first; that ordering lives in software, not in this block.

Top module: `irq_route_mapper`

## Requirements
- R1: After reset:
  - every mask bit is 1;
  - every route register reads 0;
  - the mailbox and bridge pending registers of both processors read 0;
  - all output lines are low.
- R2: The status register of a processor equals its effective source vector with the masked sources removed. A mask bit of 1 blocks its source and a mask bit of 0 passes it. Status and lines follow a source input one clock edge after it is sampled. They follow a register write one edge after the write is taken.
- R3: Each processor has a route register for source n at word address 64+n of its window (byte offset 0x200 + 8n). Its 3-bit value 0..4 picks output line 0..4. Any other value routes the source to no line, while its status bit is still reported. Line l of processor c is pin `irq_lines[c*5+l]` and is the OR of every unblocked source routed to l.
- R4: Bus word address bit 7 selects the processor window (0 or 1), and bits 6:0 select the word inside it. A write to one window leaves the other processor's registers and lines unchanged.
- R5: Inside a window, the words are:
  - word 0: mask (read/write);
  - word 1: status (read-only);
  - word 2: mailbox (direct load);
  - word 3: mailbox set port (ORs in the written 1 bits);
  - word 4: mailbox clear port (clears the written 1 bits; all ones empties it).
- R6: The mailbox raises effective source `MBOX_SRC` (26) while any bit in positions 63:48 is set. Bits below 48 raise nothing.
- R7: A 1 on `bridge_set[n]` latches pending bit n in both processors.
  - Word 5 reads the pending register, and writes to word 5 are ignored.
  - Writing 1s to word 6 clears those pending bits in that processor only.
  - A hardware set and a clear of the same bit in the same cycle leave the bit set.
  - Pending bits act as sources.
- R8: A read request produces `rd_valid` with `rd_data` on the next cycle. A write produces no `rd_valid`. Writes to status are ignored. The write-only ports (words 3, 4 and 6) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 64 | Level-sensitive interrupt sources |
| bridge_set | input | 64 | Bridge interrupt set pulses, latched into both processors' pending registers |
| bus_valid | input | 1 | Register access request, one cycle, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address: bit 7 processor, bits 6:0 word |
| bus_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Read data |
| irq_lines | output | 10 | Output request lines, processor c line l at bit c*5+l |

## Verification
The routing function is tried with these patterns, each separating a different fault:
- A single source, first fully masked and then unmasked, separates the blocking sense of the mask from the passing sense.
- The same source is moved between line 0, line 2 and an unused code. This separates the line decode from the unrouted case, in which status stays visible.
- Two sources on one line, then one of them dropped, show that a line is the OR of its sources and that it follows the input within one edge.
- Mailbox traffic on the second processor, with low bits and then a high bit, tells the mailbox source apart from plain register storage.
- A bridge pulse combined with a same-cycle clear checks the set priority. It also checks that a clear affects only one processor.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Word indices inside the register half of a processor window
  localparam int unsigned WI_MASK     = 0;
  localparam int unsigned WI_STATUS   = 1;
  localparam int unsigned WI_MBOX     = 2;
  localparam int unsigned WI_MBOX_SET = 3;
  localparam int unsigned WI_MBOX_CLR = 4;
  localparam int unsigned WI_PEND     = 5;
  localparam int unsigned WI_PEND_CLR = 6;
endpackage

// File: rtl/irq_line_or.sv
// One output line: OR of all active sources whose route selects LINE_ID
module irq_line_or #(
  parameter int NUM_SRC = 64,
  parameter int MAP_W   = 3,
  parameter int LINE_ID = 0
) (
  input  logic [NUM_SRC-1:0]       active,
  input  logic [NUM_SRC*MAP_W-1:0] map_flat,
  output logic                     hit
);
  logic [NUM_SRC-1:0] sel;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign sel[i] = active[i] && (map_flat[i*MAP_W +: MAP_W] == MAP_W'(LINE_ID));
  end

  assign hit = |sel;
endmodule

// File: rtl/irq_cpu_bank.sv
// Register bank and routing for one processor
module irq_cpu_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_LINES = 5,
  parameter int MAP_W     = 3,
  parameter int MBOX_SRC  = 26,
  parameter int MBOX_HI   = 16,
  parameter int OFF_W     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] bridge_set,
  input  logic               wr_en,
  input  logic [OFF_W-1:0]   off,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rd_word,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_LINES-1:0] lines_o
);
  localparam int IDX_W = OFF_W - 1;

  logic [NUM_SRC-1:0]   mask_q, status_q, mbox_q, pend_q;
  logic [NUM_LINES-1:0] lines_q;
  logic [MAP_W-1:0]     map_q [NUM_SRC];
  logic [NUM_SRC*MAP_W-1:0] map_flat;

  logic                 is_map;
  logic [IDX_W-1:0]     widx;
  logic [NUM_SRC-1:0]   raw, active, pend_clr, mbox_src_v;
  logic [NUM_LINES-1:0] line_hit;

  assign is_map = off[OFF_W-1];
  assign widx   = off[IDX_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flat
    assign map_flat[i*MAP_W +: MAP_W] = map_q[i];
  end

  // Effective sources: external levels, bridge pending, mailbox upper field
  assign mbox_src_v = NUM_SRC'(|mbox_q[NUM_SRC-1 -: MBOX_HI]) << MBOX_SRC;
  assign raw        = src_lvl | pend_q | mbox_src_v;
  assign active     = raw & ~mask_q;

  assign pend_clr = (wr_en && !is_map && widx == IDX_W'(WI_PEND_CLR)) ? wdata : '0;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    irq_line_or #(
      .NUM_SRC(NUM_SRC),
      .MAP_W  (MAP_W),
      .LINE_ID(l)
    ) u_line (
      .active  (active),
      .map_flat(map_flat),
      .hit     (line_hit[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      status_q <= '0;
      mbox_q   <= '0;
      pend_q   <= '0;
      lines_q  <= '0;
      for (int i = 0; i < NUM_SRC; i++) map_q[i] <= '0;
    end else begin
      status_q <= active;
      lines_q  <= line_hit;
      // hardware set wins over a same-cycle clear
      pend_q   <= (pend_q & ~pend_clr) | bridge_set;
      if (wr_en && !is_map) begin
        if (widx == IDX_W'(WI_MASK))     mask_q <= wdata;
        if (widx == IDX_W'(WI_MBOX))     mbox_q <= wdata;
        if (widx == IDX_W'(WI_MBOX_SET)) mbox_q <= mbox_q | wdata;
        if (widx == IDX_W'(WI_MBOX_CLR)) mbox_q <= mbox_q & ~wdata;
      end
      if (wr_en && is_map) map_q[widx] <= wdata[MAP_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (is_map) begin
      rd_word = NUM_SRC'(map_q[widx]);
    end else begin
      if (widx == IDX_W'(WI_MASK))   rd_word = mask_q;
      if (widx == IDX_W'(WI_STATUS)) rd_word = status_q;
      if (widx == IDX_W'(WI_MBOX))   rd_word = mbox_q;
      if (widx == IDX_W'(WI_PEND))   rd_word = pend_q;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign pend_o   = pend_q;
  assign lines_o  = lines_q;
endmodule

// File: rtl/irq_route_mapper.sv
module irq_route_mapper #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CPU   = 2,
  parameter int NUM_LINES = 5,
  parameter int MBOX_SRC  = 26,
  parameter int MBOX_HI   = 16,
  parameter int MAP_W     = $clog2(NUM_LINES + 1),
  parameter int OFF_W     = $clog2(NUM_SRC) + 1,
  parameter int ADDR_W    = OFF_W + $clog2(NUM_CPU)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           src_lvl,
  input  logic [NUM_SRC-1:0]           bridge_set,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [NUM_SRC-1:0]           bus_wdata,
  output logic                         rd_valid,
  output logic [NUM_SRC-1:0]           rd_data,
  output logic [NUM_CPU*NUM_LINES-1:0] irq_lines
);
  localparam int CPU_W = ADDR_W - OFF_W;

  logic [CPU_W-1:0]                cpu_sel;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] bank_rd;
  logic [NUM_CPU*NUM_SRC-1:0]      mask_flat, status_flat, pend_flat;
  logic                            rd_valid_q;
  logic [NUM_SRC-1:0]              rd_data_q;

  assign cpu_sel = bus_addr[ADDR_W-1:OFF_W];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_bank #(
      .NUM_SRC  (NUM_SRC),
      .NUM_LINES(NUM_LINES),
      .MAP_W    (MAP_W),
      .MBOX_SRC (MBOX_SRC),
      .MBOX_HI  (MBOX_HI),
      .OFF_W    (OFF_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_lvl   (src_lvl),
      .bridge_set(bridge_set),
      .wr_en     (bus_valid && bus_write && cpu_sel == CPU_W'(c)),
      .off       (bus_addr[OFF_W-1:0]),
      .wdata     (bus_wdata),
      .rd_word   (bank_rd[c]),
      .mask_o    (mask_flat[c*NUM_SRC +: NUM_SRC]),
      .status_o  (status_flat[c*NUM_SRC +: NUM_SRC]),
      .pend_o    (pend_flat[c*NUM_SRC +: NUM_SRC]),
      .lines_o   (irq_lines[c*NUM_LINES +: NUM_LINES])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= bus_valid && !bus_write;
      if (bus_valid && !bus_write)
        rd_data_q <= (int'(cpu_sel) < NUM_CPU) ? bank_rd[cpu_sel] : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CPU   = 2,
  parameter int NUM_LINES = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_valid,
  input logic                         bus_write,
  input logic                         rd_valid,
  input logic [NUM_SRC-1:0]           bridge_set,
  input logic [NUM_CPU*NUM_SRC-1:0]   mask_flat,
  input logic [NUM_CPU*NUM_SRC-1:0]   status_flat,
  input logic [NUM_CPU*NUM_SRC-1:0]   pend_flat,
  input logic [NUM_CPU*NUM_LINES-1:0] irq_lines
);
  p_rd_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);
  p_no_rd_otherwise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    p_status_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (status_flat[c*NUM_SRC +: NUM_SRC] & $past(mask_flat[c*NUM_SRC +: NUM_SRC])) == '0);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|bridge_set) |=> ((pend_flat[c*NUM_SRC +: NUM_SRC] & $past(bridge_set)) == $past(bridge_set)));
    p_line_has_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_lines[c*NUM_LINES +: NUM_LINES]) |-> (status_flat[c*NUM_SRC +: NUM_SRC] != '0));
  end
endmodule

bind irq_route_mapper irq_route_chk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_CPU  (NUM_CPU),
  .NUM_LINES(NUM_LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .rd_valid   (rd_valid),
  .bridge_set (bridge_set),
  .mask_flat  (mask_flat),
  .status_flat(status_flat),
  .pend_flat  (pend_flat),
  .irq_lines  (irq_lines)
);

// File: tb/tb_irq_route_mapper.sv
`timescale 1ns/1ps
module tb_irq_route_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_lvl = '0, bridge_set = '0, bus_wdata = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [9:0]  irq_lines;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string req; logic [63:0] exp; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  irq_route_mapper dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bridge_set(bridge_set),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_lines(irq_lines)
  );

  function automatic logic [7:0] reg_a(int c, int w);
    return 8'(c * 128 + w);
  endfunction
  function automatic logic [7:0] map_a(int c, int n);
    return 8'(c * 128 + 64 + n);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  // driver: push expectation, issue read; monitor compares on rd_valid
  task automatic rd(logic [7:0] a, logic [63:0] e, string req);
    exp_t it;
    it.req = req; it.exp = e;
    exp_q.push_back(it);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected rd_valid actual=%h expected=none", rd_data);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.req, rd_data, it.exp);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check("R1 lines", 64'(irq_lines), 64'h0);
    rd(reg_a(0, 0), '1, "R1 mask cpu0");
    rd(reg_a(1, 0), '1, "R1 mask cpu1");
    rd(map_a(1, 63), 64'h0, "R1 map");
    rd(reg_a(0, 2), 64'h0, "R1 mbox");
    rd(reg_a(1, 5), 64'h0, "R1 pend");

    // R2 masked source blocked
    src_lvl = 64'h1 << 3;
    idle(2);
    check("R2 masked lines", 64'(irq_lines), 64'h0);
    rd(reg_a(0, 1), 64'h0, "R2 masked status");

    // R2/R3 unmask on cpu0 routes to line 0
    wr(reg_a(0, 0), ~(64'h1 << 3));
    check("R8 no rd_valid on write", 64'(rd_valid), 64'h0);
    idle(2);
    check("R3 line0", 64'(irq_lines), 64'h1);
    rd(reg_a(0, 1), 64'h1 << 3, "R2 status cpu0");
    rd(reg_a(1, 1), 64'h0, "R4 status cpu1");

    // R3 remap to line 2, then unrouted code 6
    wr(map_a(0, 3), 64'd2);
    idle(2);
    check("R3 line2", 64'(irq_lines), 64'h4);
    rd(map_a(0, 3), 64'd2, "R3 map readback");
    wr(map_a(0, 3), 64'd6);
    idle(2);
    check("R3 unrouted", 64'(irq_lines), 64'h0);
    rd(reg_a(0, 1), 64'h1 << 3, "R3 unrouted status");

    // R3 OR of two sources, R2 one-edge follow
    wr(map_a(0, 3), 64'd0);
    src_lvl = (64'h1 << 3) | (64'h1 << 40);
    wr(reg_a(0, 0), ~((64'h1 << 3) | (64'h1 << 40)));
    idle(2);
    rd(reg_a(0, 1), (64'h1 << 3) | (64'h1 << 40), "R2 two sources");
    src_lvl = 64'h1 << 40;
    idle(1);
    check("R3 OR still high", 64'(irq_lines), 64'h1);
    src_lvl = 64'h0;
    idle(1);
    check("R2 drop follows in one edge", 64'(irq_lines), 64'h0);
    wr(reg_a(0, 0), '1);

    // R5/R6 mailbox on cpu1, source 26 on line 1
    wr(reg_a(1, 0), ~(64'h1 << 26));
    wr(map_a(1, 26), 64'd1);
    wr(reg_a(1, 3), 64'hFF);
    idle(2);
    check("R6 low bits no irq", 64'(irq_lines), 64'h0);
    wr(reg_a(1, 3), 64'h1 << 50);
    idle(2);
    check("R6 high bit raises line", 64'(irq_lines), 64'h1 << 6);
    rd(reg_a(1, 1), 64'h1 << 26, "R6 status");
    rd(reg_a(1, 2), 64'hFF | (64'h1 << 50), "R5 set port");
    rd(reg_a(0, 2), 64'h0, "R4 other mbox");
    rd(reg_a(1, 4), 64'h0, "R8 clr port reads 0");
    wr(reg_a(1, 4), '1);
    idle(2);
    check("R5 clear drops line", 64'(irq_lines), 64'h0);
    rd(reg_a(1, 2), 64'h0, "R5 clear all");
    wr(reg_a(0, 2), 64'h1234);
    idle(1);
    rd(reg_a(0, 2), 64'h1234, "R5 direct load");

    // R7 bridge pending
    bridge_set = 64'h1 << 10;
    idle(1);
    bridge_set = 64'h0;
    rd(reg_a(0, 5), 64'h1 << 10, "R7 pend cpu0");
    rd(reg_a(1, 5), 64'h1 << 10, "R7 pend cpu1");
    wr(reg_a(0, 0), ~(64'h1 << 10));
    wr(map_a(0, 10), 64'd4);
    idle(2);
    check("R7 pend as source", 64'(irq_lines), 64'h1 << 4);
    bridge_set = 64'h1 << 10;
    wr(reg_a(0, 6), 64'h1 << 10);
    bridge_set = 64'h0;
    idle(1);
    rd(reg_a(0, 5), 64'h1 << 10, "R7 set wins");
    wr(reg_a(0, 6), 64'h1 << 10);
    idle(2);
    rd(reg_a(0, 5), 64'h0, "R7 clear");
    check("R7 line off", 64'(irq_lines), 64'h0);
    rd(reg_a(1, 5), 64'h1 << 10, "R7 other cpu kept");
    wr(reg_a(1, 5), 64'h0);
    idle(1);
    rd(reg_a(1, 5), 64'h1 << 10, "R7 pend write ignored");

    // R8 status write ignored
    wr(reg_a(0, 1), '1);
    idle(2);
    rd(reg_a(0, 1), 64'h0, "R8 status write ignored");

    idle(3);
    check("R8 all reads returned", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule